// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block turns one request to move a group of 32-bit registers into a series of single-word memory transfers. It takes a base address, a 16-bit register mask and two mode bits. The first mode bit picks ascending or descending placement, and the second picks whether the address steps before or after each word. It checks the mask from the lowest index to the highest. For each set bit it issues one word transfer and names the register that belongs to it. In both modes the addresses rise by one word per transfer. When the last word is done, it reports the address that the base register is to be updated with, together with the cost of the burst in cycles.

A caller starts a burst with a one-cycle start pulse while the block is idle. The transfers then go out on a valid/ready interface, one word per handshake. A region-hit flag comes in with the start. It marks the burst as mapped or unmapped. For an unmapped burst the sequence still runs in full, but loads return zero and stores raise no write enable. Memory storage, register files and address decoding stay outside this block.

Top module: `lsm_seq`

## Requirements
- R1: The mask is walked from index 0 to index 15. Each set bit gives exactly one transfer, and `xfer_reg_o` carries that bit's index. The transfer address rises by 4 after every accepted word.
- R2: In ascending mode (`dec_i`=0) the first address is the base. With `pre_i`=1 it is the base plus 4.
- R3: In descending mode (`dec_i`=1) the first address is the base minus 4 times the number of set mask bits, plus 4. With `pre_i`=1 it is a further 4 lower. Transfers still rise from there.
- R4: Every transfer address has its two low bits at zero. The two low bits of the reported final address equal those of the base.
- R5: `final_addr_o` (valid with `done_o`) is the base plus 4 times the set-bit count when ascending, and the base minus that amount when descending. `pre_i` has no effect on it.
- R6: `cost_o` (valid with `done_o`) is the number of words moved, plus one for a load. A store raises `done_o` in the cycle after its last accepted word. A load raises it one cycle later.
- R7: With `hit_i`=0, a load still runs through every set bit and `reg_wdata_o` is zero for each word. A store raises no `xfer_we_o`. With `hit_i`=1, a store raises `xfer_we_o` on each word, and a load passes `mem_rdata_i` to `reg_wdata_o`.
- R8: An all-zero mask makes no transfer. `done_o` rises in the cycle after the start, and the final address equals the base.
- R9: `start_i` is ignored while `busy_o` is high. `done_o` is a one-cycle pulse, and `busy_o` is low while it is high.
- R10: While `xfer_valid_o` is high and `xfer_ready_i` is low, the address and register index hold, and no mask position is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start a burst (taken only when idle) |
| base_i | input | 32 | Base address |
| mask_i | input | 16 | Register select mask |
| dec_i | input | 1 | 1 = descending placement |
| pre_i | input | 1 | 1 = step before the transfer |
| load_i | input | 1 | 1 = load burst, 0 = store burst |
| hit_i | input | 1 | 1 = address lies in a mapped region |
| busy_o | output | 1 | Burst in progress |
| done_o | output | 1 | One-cycle completion pulse |
| final_addr_o | output | 32 | Writeback address, valid with done_o |
| cost_o | output | 5 | Burst cost in cycles, valid with done_o |
| xfer_valid_o | output | 1 | Word transfer pending |
| xfer_ready_i | input | 1 | Memory side accepts the word |
| xfer_addr_o | output | 32 | Word-aligned transfer address |
| xfer_reg_o | output | 4 | Register index of this word |
| xfer_we_o | output | 1 | Write enable for a mapped store |
| mem_rdata_i | input | 32 | Read data from memory |
| reg_wdata_o | output | 32 | Data for the named register (zero if unmapped) |

## Verification
The bench aims at descending placement with and without the pre-step. An error in the popcount offset there shows up as a whole burst shifted by a word, or as a writeback address that moves with `pre_i`. Bases with nonzero low bits expose a design that lets those bits leak onto the transfer address or drops them from the final address. Irregular ready patterns and a start pulse in the middle of a burst catch skipped or repeated registers and restarts that clobber a running burst. Zero masks, unmapped loads and stores, and the one-cycle load tail check the edges of the cost and done timing.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_TAIL = 2'd2
  } seq_state_e;
endpackage

// File: rtl/lsm_first_set.sv
module lsm_first_set #(
  parameter int N = 16,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  output logic [N-1:0]  onehot_o,
  output logic [IW-1:0] idx_o
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar g = 0; g < N; g++) begin : g_chain
    assign onehot_o[g] = vec_i[g] & ~seen[g];
    assign seen[g+1]   = seen[g] | vec_i[g];
  end

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (onehot_o[i]) idx_o = idx_o | IW'(i);
    end
  end
endmodule

// File: rtl/lsm_span_calc.sv
module lsm_span_calc #(
  parameter int AW    = 32,
  parameter int NREG  = 16,
  parameter int BYTES = 4,
  localparam int LOW_W = $clog2(BYTES),
  localparam int PC_W  = $clog2(NREG + 1)
) (
  input  logic [AW-1:0]   base_i,
  input  logic [NREG-1:0] mask_i,
  input  logic            dec_i,
  input  logic            pre_i,
  output logic [AW-1:0]   first_addr_o,
  output logic [AW-1:0]   final_addr_o
);
  logic [PC_W-1:0] pc;
  logic [AW-1:0]   span;
  logic [AW-1:0]   start;
  logic [AW-1:0]   fin;

  always_comb begin
    pc = '0;
    for (int i = 0; i < NREG; i++) pc = pc + PC_W'(mask_i[i]);
  end

  assign span = AW'(pc) << LOW_W;

  always_comb begin
    if (dec_i) start = base_i - span + AW'(BYTES);
    else       start = base_i;
    if (pre_i) start = dec_i ? start - AW'(BYTES) : start + AW'(BYTES);
    fin = dec_i ? base_i - span : base_i + span;
  end

  assign first_addr_o = {start[AW-1:LOW_W], {LOW_W{1'b0}}};
  assign final_addr_o = {fin[AW-1:LOW_W], start[LOW_W-1:0]};
endmodule

// File: rtl/lsm_seq.sv
module lsm_seq #(
  parameter int AW    = 32,
  parameter int NREG  = 16,
  parameter int BYTES = 4,
  parameter int DW    = 32,
  localparam int IW   = $clog2(NREG),
  localparam int CW   = $clog2(NREG + 2)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  input  logic [AW-1:0]   base_i,
  input  logic [NREG-1:0] mask_i,
  input  logic            dec_i,
  input  logic            pre_i,
  input  logic            load_i,
  input  logic            hit_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [AW-1:0]   final_addr_o,
  output logic [CW-1:0]   cost_o,
  output logic            xfer_valid_o,
  input  logic            xfer_ready_i,
  output logic [AW-1:0]   xfer_addr_o,
  output logic [IW-1:0]   xfer_reg_o,
  output logic            xfer_we_o,
  input  logic [DW-1:0]   mem_rdata_i,
  output logic [DW-1:0]   reg_wdata_o
);
  import lsm_pkg::*;

  seq_state_e      state_q;
  logic [AW-1:0]   addr_q;
  logic [AW-1:0]   fin_q;
  logic [NREG-1:0] rem_q;
  logic            load_q;
  logic            hit_q;
  logic            done_q;
  logic [CW-1:0]   cnt_q;
  logic [CW-1:0]   cost_q;

  logic [AW-1:0]   first_addr;
  logic [AW-1:0]   fin_addr;
  logic [NREG-1:0] low_oh;
  logic [IW-1:0]   low_idx;
  logic [NREG-1:0] rem_next;

  lsm_span_calc #(.AW(AW), .NREG(NREG), .BYTES(BYTES)) u_span (
    .base_i       (base_i),
    .mask_i       (mask_i),
    .dec_i        (dec_i),
    .pre_i        (pre_i),
    .first_addr_o (first_addr),
    .final_addr_o (fin_addr)
  );

  lsm_first_set #(.N(NREG)) u_first (
    .vec_i    (rem_q),
    .onehot_o (low_oh),
    .idx_o    (low_idx)
  );

  assign rem_next = rem_q & ~low_oh;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      fin_q   <= '0;
      rem_q   <= '0;
      load_q  <= 1'b0;
      hit_q   <= 1'b0;
      done_q  <= 1'b0;
      cnt_q   <= '0;
      cost_q  <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            addr_q <= first_addr;
            fin_q  <= fin_addr;
            rem_q  <= mask_i;
            load_q <= load_i;
            hit_q  <= hit_i;
            cnt_q  <= '0;
            if (mask_i == '0) begin
              done_q <= 1'b1;
              cost_q <= CW'(load_i);
            end else begin
              state_q <= ST_RUN;
            end
          end
        end
        ST_RUN: begin
          if (xfer_ready_i) begin
            rem_q  <= rem_next;
            addr_q <= addr_q + AW'(BYTES);
            cnt_q  <= cnt_q + 1'b1;
            if (rem_next == '0) begin
              if (load_q) begin
                state_q <= ST_TAIL;
              end else begin
                state_q <= ST_IDLE;
                done_q  <= 1'b1;
                cost_q  <= cnt_q + 1'b1;
              end
            end
          end
        end
        ST_TAIL: begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
          cost_q  <= cnt_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o       = (state_q != ST_IDLE);
  assign done_o       = done_q;
  assign final_addr_o = fin_q;
  assign cost_o       = cost_q;
  assign xfer_valid_o = (state_q == ST_RUN);
  assign xfer_addr_o  = addr_q;
  assign xfer_reg_o   = low_idx;
  assign xfer_we_o    = (state_q == ST_RUN) && !load_q && hit_q;
  assign reg_wdata_o  = (load_q && hit_q && state_q == ST_RUN) ? mem_rdata_i : '0;
endmodule

// File: rtl/lsm_seq_chk.sv
module lsm_seq_chk #(
  parameter int AW   = 32,
  parameter int NREG = 16,
  localparam int IW  = $clog2(NREG)
) (
  input logic          clk,
  input logic          rst,
  input logic          busy_o,
  input logic          done_o,
  input logic          xfer_valid_o,
  input logic          xfer_ready_i,
  input logic [AW-1:0] xfer_addr_o,
  input logic [IW-1:0] xfer_reg_o,
  input logic          xfer_we_o
);
  assert_step_R1: assert property (@(posedge clk) disable iff (rst)
    (xfer_valid_o && xfer_ready_i) |=> (!xfer_valid_o || xfer_addr_o == $past(xfer_addr_o) + AW'(4)));

  assert_reg_rises_R1: assert property (@(posedge clk) disable iff (rst)
    (xfer_valid_o && xfer_ready_i) |=> (!xfer_valid_o || xfer_reg_o > $past(xfer_reg_o)));

  assert_aligned_R4: assert property (@(posedge clk) disable iff (rst)
    xfer_valid_o |-> (xfer_addr_o[1:0] == 2'b00));

  assert_we_in_burst_R7: assert property (@(posedge clk) disable iff (rst)
    xfer_we_o |-> xfer_valid_o);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  assert_valid_busy_R9: assert property (@(posedge clk) disable iff (rst)
    xfer_valid_o |-> busy_o);

  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (xfer_valid_o && !xfer_ready_i) |=> (xfer_valid_o && $stable(xfer_addr_o) && $stable(xfer_reg_o)));
endmodule

bind lsm_seq lsm_seq_chk #(.AW(AW), .NREG(NREG)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .xfer_valid_o (xfer_valid_o),
  .xfer_ready_i (xfer_ready_i),
  .xfer_addr_o  (xfer_addr_o),
  .xfer_reg_o   (xfer_reg_o),
  .xfer_we_o    (xfer_we_o)
);

// File: tb/lsm_seq_bench.sv
`timescale 1ns/1ps
module lsm_seq_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [31:0] base_i = '0;
  logic [15:0] mask_i = '0;
  logic        dec_i = 1'b0, pre_i = 1'b0, load_i = 1'b0, hit_i = 1'b0;
  logic        xfer_ready_i = 1'b0;
  logic        busy_o, done_o, xfer_valid_o, xfer_we_o;
  logic [31:0] final_addr_o, xfer_addr_o, mem_rdata_i, reg_wdata_o;
  logic [4:0]  cost_o;
  logic [3:0]  xfer_reg_o;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  assign mem_rdata_i = {xfer_addr_o[15:0], ~xfer_addr_o[15:0]};

  lsm_seq u_lsm_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .base_i(base_i), .mask_i(mask_i),
    .dec_i(dec_i), .pre_i(pre_i), .load_i(load_i), .hit_i(hit_i),
    .busy_o(busy_o), .done_o(done_o), .final_addr_o(final_addr_o), .cost_o(cost_o),
    .xfer_valid_o(xfer_valid_o), .xfer_ready_i(xfer_ready_i), .xfer_addr_o(xfer_addr_o),
    .xfer_reg_o(xfer_reg_o), .xfer_we_o(xfer_we_o), .mem_rdata_i(mem_rdata_i),
    .reg_wdata_o(reg_wdata_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      finish_run();
    end
  end

  task automatic run_op(input logic [31:0] base, input logic [15:0] mask,
                        input bit dec, input bit pre, input bit ld, input bit hit,
                        input logic [15:0] rpat, input bit poke);
    int pc = 0;
    logic [31:0] q_addr[$];
    int q_reg[$];
    logic [31:0] s, fin, a;
    int cnt;
    bit popped = 0;
    bit stalled = 0;
    int it;
    string atag;
    for (int i = 0; i < 16; i++) if (mask[i]) pc++;
    s = base;
    if (dec) s = base - 32'(4 * pc) + 32'd4;
    if (pre) s = dec ? s - 32'd4 : s + 32'd4;
    a = s & 32'hFFFF_FFFC;
    for (int i = 0; i < 16; i++) begin
      if (mask[i]) begin
        q_addr.push_back(a);
        q_reg.push_back(i);
        a = a + 32'd4;
      end
    end
    fin = dec ? base - 32'(4 * pc) : base + 32'(4 * pc);
    fin = (fin & 32'hFFFF_FFFC) | (base & 32'd3);
    atag = dec ? "R3" : "R2";

    @(negedge clk);
    start_i = 1'b1; base_i = base; mask_i = mask;
    dec_i = dec; pre_i = pre; load_i = ld; hit_i = hit; xfer_ready_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    cnt = (pc == 0) ? 0 : -1;
    for (it = 0; it < 300; it++) begin
      if (popped) begin
        void'(q_addr.pop_front());
        void'(q_reg.pop_front());
        if (q_addr.size() == 0) cnt = ld ? 1 : 0;
        popped = 0;
      end else if (cnt > 0) begin
        cnt--;
      end
      chk("R9 busy", 32'(busy_o), 32'((q_addr.size() > 0) || cnt == 1));
      chk("R1 valid", 32'(xfer_valid_o), 32'(q_addr.size() > 0));
      if (q_addr.size() > 0) begin
        chk(stalled ? "R10 held addr" : atag, xfer_addr_o, q_addr[0]);
        chk(stalled ? "R10 held reg" : "R1 reg", 32'(xfer_reg_o), 32'(q_reg[0]));
        chk("R4 align", 32'(xfer_addr_o[1:0]), 32'd0);
        chk("R7 we", 32'(xfer_we_o), 32'(!ld && hit));
        if (ld) chk("R7 rdata", reg_wdata_o, hit ? {q_addr[0][15:0], ~q_addr[0][15:0]} : 32'd0);
      end
      chk((pc == 0) ? "R8 done" : "R6 done", 32'(done_o), 32'(cnt == 0));
      if (cnt == 0) begin
        chk((pc == 0) ? "R8 final" : "R5 final", final_addr_o, fin);
        chk("R6 cost", 32'(cost_o), 32'(pc + (ld ? 1 : 0)));
        break;
      end
      xfer_ready_i = rpat[it % 16];
      popped  = (q_addr.size() > 0) && xfer_ready_i;
      stalled = (q_addr.size() > 0) && !xfer_ready_i;
      start_i = poke && (it == 1);
      if (poke && it == 1) begin
        base_i = 32'h7777_0000; mask_i = 16'hFFFF; dec_i = ~dec;
      end
      @(negedge clk);
    end
    if (it >= 300) begin
      n_bad++;
      $display("FAIL R6 burst-end actual=timeout expected=done");
    end
    start_i = 1'b0;
    xfer_ready_i = 1'b0;
    @(negedge clk);
    chk("R9 idle after done", 32'({busy_o, xfer_valid_o, done_o}), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R9 reset busy", 32'(busy_o), 32'd0);
    chk("R1 reset valid", 32'(xfer_valid_o), 32'd0);
    chk("R6 reset done", 32'(done_o), 32'd0);

    run_op(32'h0000_1000, 16'h0005, 0, 0, 1, 1, 16'hFFFF, 0);
    run_op(32'h0000_2000, 16'h8421, 1, 0, 0, 1, 16'hA5A5, 0);
    run_op(32'h0000_3010, 16'hFFFF, 1, 1, 1, 1, 16'h3C3D, 0);
    run_op(32'h0000_1003, 16'h00F0, 0, 1, 0, 1, 16'hFFFF, 0);
    run_op(32'h0000_4000, 16'h0303, 0, 0, 1, 0, 16'hF0F1, 0);
    run_op(32'h0000_4800, 16'h0C00, 1, 0, 0, 0, 16'hFFFF, 0);
    run_op(32'h0000_5002, 16'h0000, 0, 0, 1, 1, 16'hFFFF, 0);
    run_op(32'h0000_5002, 16'h0000, 1, 1, 0, 1, 16'hFFFF, 0);
    run_op(32'h0000_6000, 16'h0E01, 0, 0, 1, 1, 16'hFFFF, 1);
    run_op(32'h0000_0002, 16'h0001, 1, 1, 1, 1, 16'h0001, 0);
    run_op(32'h0000_8001, 16'h8000, 1, 0, 0, 1, 16'h1111, 0);
    finish_run();
  end
endmodule